// File: doc/BRIEF.md
# Interval Timer Register Front End

This block is the byte-wide register interface that sits in front of three interval counters. It has a two-bit address. Addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2. Address 3 is the command port. The block programs each channel's counting mode, BCD flag and byte access order. It freezes a channel's count or status on request and serves those frozen values back through the data ports. It also assembles count bytes written by software into a full 16-bit reload value.

The counters themselves live outside the block. They supply their live count and their output level to this block. In return they receive a one-cycle load strobe carrying the new reload value. Each counter answers with a pulse when it has actually taken that value. The block uses that pulse to maintain a per-channel "count not yet in use" flag, which appears in the status byte.

Top module: `timer_regfront`

## Requirements
- R1: After reset every channel has mode 0, BCD 0 and access code 3 (two-byte), no frozen count or status is pending, the not-yet-loaded flag is 0 and no load strobe is active.
- R2: A write to address 3 with bits 7:6 equal to 0, 1 or 2 and a non-zero field in bits 5:4 programs that channel. Bits 5:4 become the access code (1 low byte, 2 high byte, 3 low then high). Bits 3:1 become the mode, with 6 and 7 taken as 2 and 3. Bit 0 becomes the BCD flag. The outputs show the new values after the next clock edge.
- R3: A command-port write with bits 5:4 equal to 0 freezes the selected channel's live count and leaves its mode, access code and BCD flag unchanged.
- R4: A freeze request for a count is ignored while a frozen count of that channel is still unread. A status freeze is likewise ignored while a frozen status is unread.
- R5: A command-port write with bits 7:6 equal to 3 is a multi-channel capture. Bits 1, 2 and 3 select channels 0, 1 and 2. If bit 5 is 0 the count of each selected channel is frozen. If bit 4 is 0 its status is frozen.
- R6: The status byte holds, from bit 7 down: the output level at capture time, the not-yet-loaded flag, the access code (2 bits), the mode (3 bits) and the BCD flag.
- R7: A data-port read returns the frozen status if one is pending, and one read clears it. Otherwise it returns the frozen count: the low byte for access code 1, the high byte for code 2, or low then high for code 3. The freeze clears after its last byte. Otherwise the read returns the live count in the access order, alternating between low and high bytes in two-byte mode.
- R8: A data-port write with access code 1 loads {0x00, byte}. With code 2 it loads {byte, 0x00}. With code 3 the first write is held, and the second write loads {second, first}. The load strobe of that channel is high for exactly one cycle, starting after the clock edge that takes the completing write.
- R9: Programming a channel (R2) restarts both its write and its live-read byte sequences at the low byte.
- R10: A read of address 3 returns 0x00 and changes no state.
- R11: The not-yet-loaded flag is set when a load strobe is issued. It is cleared by the channel's taken pulse. If both happen in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write access this cycle |
| rd_en | input | 1 | Read access this cycle (side effects at the clock edge) |
| addr | input | 2 | 0..2 channel data port, 3 command port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr and state |
| live_count | input | 48 | Live count of each channel, channel n at bits 16n+15:16n |
| out_lvl | input | 3 | Output level of each channel |
| cnt_taken | input | 3 | Pulse from a counter when it has taken its reload value |
| load_stb | output | 3 | One-cycle reload strobe per channel |
| load_val | output | 48 | Reload value per channel, valid with its strobe |
| ch_mode | output | 9 | Mode per channel, 3 bits each |
| ch_bcd | output | 3 | BCD flag per channel |
| ch_access | output | 6 | Access code per channel, 2 bits each |

## Verification
The bench changes the live count after a freeze and requests a second freeze. A design that overwrites a pending freeze then returns the newer value. It also freezes count and status together. A wrong read priority then shows the count bytes before the status, or the bytes out of order. A second command word is placed between the two halves of a two-byte write, so a design that keeps its byte toggle loads a mixed value. Mode codes 6 and 7 are programmed, and so are reads of the command port in the middle of a byte sequence. These catch a missing remap and a spurious toggle advance.

// File: rtl/tcf_pkg.sv
package tcf_pkg;
    localparam int NCH    = 3;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int MODE_W = 3;
    localparam int ACC_W  = 2;
    localparam int STS_W  = BYTE_W;

    typedef enum logic [ACC_W-1:0] {
        ACC_LATCH = 2'd0,
        ACC_LO    = 2'd1,
        ACC_HI    = 2'd2,
        ACC_WORD  = 2'd3
    } acc_e;

    typedef struct packed {
        logic set_mode;
        logic latch_cnt;
        logic latch_sts;
        logic data_wr;
    } chan_cmd_t;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              bcd;
        acc_e              acc;
        logic              wr_hi;
        logic [BYTE_W-1:0] wr_hold;
        logic              rd_hi;
        logic [CNT_W-1:0]  cnt_lat;
        acc_e              cnt_pend;
        logic [STS_W-1:0]  sts_lat;
        logic              sts_pend;
        logic              null_cnt;
        logic              ld_stb;
        logic [CNT_W-1:0]  ld_val;
    } chan_st_t;
endpackage

// File: rtl/tcf_cmd_decode.sv
module tcf_cmd_decode
    import tcf_pkg::*;
(
    input  logic                       wr_en,
    input  logic [1:0]                 addr,
    input  logic [BYTE_W-1:0]          wdata,
    output chan_cmd_t [NCH-1:0]        cmd,
    output logic [MODE_W-1:0]          mode_f,
    output acc_e                       acc_f,
    output logic                       bcd_f
);
    localparam logic [1:0] CMD_ADDR = 2'd3;
    localparam logic [1:0] SEL_CAPT = 2'd3;

    logic       ctl_wr;
    logic [1:0] sel;
    logic       capt;
    logic [MODE_W-1:0] raw_mode;

    always_comb begin
        ctl_wr   = wr_en && (addr == CMD_ADDR);
        sel      = wdata[7:6];
        capt     = (sel == SEL_CAPT);
        raw_mode = wdata[3:1];
        mode_f   = (raw_mode > 3'd5) ? raw_mode - 3'd4 : raw_mode;
        acc_f    = acc_e'(wdata[5:4]);
        bcd_f    = wdata[0];
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        always_comb begin
            cmd[i].set_mode  = ctl_wr && !capt && (sel == 2'(i)) && (wdata[5:4] != 2'd0);
            cmd[i].latch_cnt = ctl_wr && ((!capt && (sel == 2'(i)) && (wdata[5:4] == 2'd0))
                                       || (capt && wdata[i+1] && !wdata[5]));
            cmd[i].latch_sts = ctl_wr && capt && wdata[i+1] && !wdata[4];
            cmd[i].data_wr   = wr_en && (addr == 2'(i));
        end
    end
endmodule

// File: rtl/tcf_chan.sv
module tcf_chan
    import tcf_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  chan_cmd_t           cmd,
    input  logic [MODE_W-1:0]   mode_f,
    input  acc_e                acc_f,
    input  logic                bcd_f,
    input  logic [BYTE_W-1:0]   wdata,
    input  logic                rd_sel,
    input  logic [CNT_W-1:0]    live_cnt,
    input  logic                out_lvl,
    input  logic                took,
    output logic [BYTE_W-1:0]   rd_byte,
    output logic [MODE_W-1:0]   mode,
    output logic                bcd,
    output logic [ACC_W-1:0]    acc,
    output logic                ld_stb,
    output logic [CNT_W-1:0]    ld_val
);
    chan_st_t st_q, st_d;

    always_comb begin
        // read data mux: status, then frozen count, then live count
        if (st_q.sts_pend) begin
            rd_byte = st_q.sts_lat;
        end else if (st_q.cnt_pend != ACC_LATCH) begin
            rd_byte = (st_q.cnt_pend == ACC_HI) ? st_q.cnt_lat[CNT_W-1:BYTE_W]
                                                : st_q.cnt_lat[BYTE_W-1:0];
        end else begin
            case (st_q.acc)
                ACC_HI:   rd_byte = live_cnt[CNT_W-1:BYTE_W];
                ACC_WORD: rd_byte = st_q.rd_hi ? live_cnt[CNT_W-1:BYTE_W]
                                               : live_cnt[BYTE_W-1:0];
                default:  rd_byte = live_cnt[BYTE_W-1:0];
            endcase
        end
    end

    always_comb begin
        st_d        = st_q;
        st_d.ld_stb = 1'b0;

        if (took) st_d.null_cnt = 1'b0;

        // read side effects
        if (rd_sel) begin
            if (st_q.sts_pend) begin
                st_d.sts_pend = 1'b0;
            end else if (st_q.cnt_pend != ACC_LATCH) begin
                st_d.cnt_pend = (st_q.cnt_pend == ACC_WORD) ? ACC_HI : ACC_LATCH;
            end else if (st_q.acc == ACC_WORD) begin
                st_d.rd_hi = !st_q.rd_hi;
            end
        end

        if (cmd.set_mode) begin
            st_d.mode  = mode_f;
            st_d.acc   = acc_f;
            st_d.bcd   = bcd_f;
            st_d.wr_hi = 1'b0;
            st_d.rd_hi = 1'b0;
        end

        if (cmd.latch_cnt && (st_q.cnt_pend == ACC_LATCH)) begin
            st_d.cnt_lat  = live_cnt;
            st_d.cnt_pend = st_q.acc;
        end

        if (cmd.latch_sts && !st_q.sts_pend) begin
            st_d.sts_lat  = {out_lvl, st_q.null_cnt, st_q.acc, st_q.mode, st_q.bcd};
            st_d.sts_pend = 1'b1;
        end

        if (cmd.data_wr) begin
            case (st_q.acc)
                ACC_HI: begin
                    st_d.ld_stb = 1'b1;
                    st_d.ld_val = {wdata, {BYTE_W{1'b0}}};
                end
                ACC_WORD: begin
                    if (!st_q.wr_hi) begin
                        st_d.wr_hold = wdata;
                        st_d.wr_hi   = 1'b1;
                    end else begin
                        st_d.ld_stb = 1'b1;
                        st_d.ld_val = {wdata, st_q.wr_hold};
                        st_d.wr_hi  = 1'b0;
                    end
                end
                default: begin
                    st_d.ld_stb = 1'b1;
                    st_d.ld_val = {{BYTE_W{1'b0}}, wdata};
                end
            endcase
            if (st_d.ld_stb) st_d.null_cnt = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.acc <= ACC_WORD;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode   = st_q.mode;
    assign bcd    = st_q.bcd;
    assign acc    = st_q.acc;
    assign ld_stb = st_q.ld_stb;
    assign ld_val = st_q.ld_val;

    // R2: a programmed mode never leaves the legal range
    a_r2_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mode <= 3'd5);
    // R4: a pending frozen count is not replaced until it is read
    a_r4_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt_pend != ACC_LATCH && !rd_sel) |=> $stable(st_q.cnt_lat));
    // R4: a pending frozen status is not replaced until it is read
    a_r4_sts_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sts_pend && !rd_sel) |=> $stable(st_q.sts_lat));
    // R9: programming restarts both byte sequences
    a_r9_seq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.set_mode && !cmd.data_wr && !rd_sel) |=> (!st_q.wr_hi && !st_q.rd_hi));
    // R11: a strobe is always accompanied by the not-yet-loaded flag
    a_r11_null_set: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ld_stb |-> st_q.null_cnt);
endmodule

// File: rtl/timer_regfront.sv
module timer_regfront
    import tcf_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [1:0]              addr,
    input  logic [BYTE_W-1:0]       wdata,
    output logic [BYTE_W-1:0]       rdata,
    input  logic [NCH*CNT_W-1:0]    live_count,
    input  logic [NCH-1:0]          out_lvl,
    input  logic [NCH-1:0]          cnt_taken,
    output logic [NCH-1:0]          load_stb,
    output logic [NCH*CNT_W-1:0]    load_val,
    output logic [NCH*MODE_W-1:0]   ch_mode,
    output logic [NCH-1:0]          ch_bcd,
    output logic [NCH*ACC_W-1:0]    ch_access
);
    chan_cmd_t [NCH-1:0]   cmd;
    logic [MODE_W-1:0]     mode_f;
    acc_e                  acc_f;
    logic                  bcd_f;
    logic [BYTE_W-1:0]     rd_byte [NCH];

    tcf_cmd_decode u_dec (
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .cmd    (cmd),
        .mode_f (mode_f),
        .acc_f  (acc_f),
        .bcd_f  (bcd_f)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        tcf_chan u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmd      (cmd[i]),
            .mode_f   (mode_f),
            .acc_f    (acc_f),
            .bcd_f    (bcd_f),
            .wdata    (wdata),
            .rd_sel   (rd_en && (addr == 2'(i))),
            .live_cnt (live_count[i*CNT_W +: CNT_W]),
            .out_lvl  (out_lvl[i]),
            .took     (cnt_taken[i]),
            .rd_byte  (rd_byte[i]),
            .mode     (ch_mode[i*MODE_W +: MODE_W]),
            .bcd      (ch_bcd[i]),
            .acc      (ch_access[i*ACC_W +: ACC_W]),
            .ld_stb   (load_stb[i]),
            .ld_val   (load_val[i*CNT_W +: CNT_W])
        );
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (addr == 2'(i)) rdata = rd_byte[i];
        end
    end

    // R8: at most one channel loads per cycle
    a_r8_one_load: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_stb));
    // R10: the command port reads as zero
    a_r10_cmd_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 2'd3) |-> (rdata == '0));
endmodule

// File: tb/sim_timer_regfront.sv
`timescale 1ns/1ps
module sim_timer_regfront;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [7:0]  wdata = 8'd0;
    logic [7:0]  rdata;
    logic [47:0] live_count;
    logic [2:0]  out_lvl;
    logic [2:0]  cnt_taken = 3'b000;
    logic [2:0]  load_stb;
    logic [47:0] load_val;
    logic [8:0]  ch_mode;
    logic [2:0]  ch_bcd;
    logic [5:0]  ch_access;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    timer_regfront u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .live_count(live_count), .out_lvl(out_lvl),
        .cnt_taken(cnt_taken), .load_stb(load_stb), .load_val(load_val),
        .ch_mode(ch_mode), .ch_bcd(ch_bcd), .ch_access(ch_access)
    );

    // {is_read, addr, data-or-expected}
    localparam int NV = 18;
    localparam logic [10:0] VEC [NV] = '{
        {1'b1, 2'd0, 8'h34}, {1'b1, 2'd0, 8'h12}, {1'b1, 2'd3, 8'h00},
        {1'b0, 2'd3, 8'h16}, {1'b1, 2'd0, 8'h34}, {1'b1, 2'd0, 8'h34},
        {1'b0, 2'd3, 8'hE2}, {1'b1, 2'd0, 8'h96}, {1'b1, 2'd0, 8'h34},
        {1'b0, 2'd3, 8'h5F}, {1'b0, 2'd3, 8'hE4}, {1'b1, 2'd1, 8'h17},
        {1'b0, 2'd3, 8'h6C}, {1'b0, 2'd3, 8'hE4}, {1'b1, 2'd1, 8'h24},
        {1'b1, 2'd1, 8'hAB}, {1'b0, 2'd3, 8'h90}, {1'b1, 2'd2, 8'h66}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1;
        check(req, rdata, exp);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        live_count = {16'h5566, 16'hABCD, 16'h1234};
        out_lvl    = 3'b101;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 mode", ch_mode, 9'd0);
        check("R1 bcd", ch_bcd, 3'd0);
        check("R1 access", ch_access, 6'h3F);
        check("R1 strobe", load_stb, 3'd0);
        wr(2'd3, 8'hE8);
        rd(2'd2, 8'hB0, "R1 R6 reset status ch2");

        // R7 table of mixed accesses
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][10]) rd(VEC[i][9:8], VEC[i][7:0], "R7 table read");
            else            wr(VEC[i][9:8], VEC[i][7:0]);
        end

        // R3 / R4: freeze, change live value, second freeze ignored
        wr(2'd3, 8'hB4);
        wr(2'd3, 8'h80);
        check("R3 mode kept", ch_mode[8:6], 3'd2);
        check("R3 access kept", ch_access[5:4], 2'd3);
        live_count[47:32] = 16'h7788;
        wr(2'd3, 8'h80);
        rd(2'd2, 8'h66, "R4 frozen low");
        rd(2'd2, 8'h55, "R4 frozen high");
        rd(2'd2, 8'h88, "R7 live low after freeze");
        rd(2'd2, 8'h77, "R7 live high");

        // R4 status freeze ignored while pending
        out_lvl[2] = 1'b1;
        wr(2'd3, 8'hE8);
        out_lvl[2] = 1'b0;
        wr(2'd3, 8'hE8);
        rd(2'd2, 8'hB4, "R4 first status kept");
        rd(2'd2, 8'h88, "R7 live after status");
        rd(2'd2, 8'h77, "R7 live high 2");

        // R5 count and status together
        out_lvl[2] = 1'b1;
        wr(2'd3, 8'hC8);
        live_count[47:32] = 16'h0102;
        rd(2'd2, 8'hB4, "R5 status first");
        rd(2'd2, 8'h88, "R5 count low");
        rd(2'd2, 8'h77, "R5 count high");
        rd(2'd2, 8'h02, "R5 back to live");

        // R8 / R11 two-byte write, flag set and cleared
        wr(2'd3, 8'h34);
        wr(2'd0, 8'h21);
        check("R8 no strobe after first byte", load_stb, 3'd0);
        wr(2'd0, 8'h43);
        check("R8 word strobe", load_stb, 3'b001);
        check("R8 word value", load_val[15:0], 16'h4321);
        @(negedge clk);
        check("R8 strobe one cycle", load_stb, 3'd0);
        wr(2'd3, 8'hE2);
        rd(2'd0, 8'hF4, "R11 flag set in status");
        @(negedge clk); cnt_taken = 3'b001;
        @(negedge clk); cnt_taken = 3'b000;
        wr(2'd3, 8'hE2);
        rd(2'd0, 8'hB4, "R11 flag cleared");

        // R8 high-only and low-only
        wr(2'd3, 8'h24);
        wr(2'd0, 8'h9A);
        check("R8 high value", load_val[15:0], 16'h9A00);
        wr(2'd3, 8'h14);
        wr(2'd0, 8'h5B);
        check("R8 low value", load_val[15:0], 16'h005B);

        // R9 command word restarts write and read sequences
        wr(2'd3, 8'h34);
        wr(2'd0, 8'h11);
        wr(2'd3, 8'h34);
        wr(2'd0, 8'h22);
        check("R9 write restarted", load_stb, 3'd0);
        wr(2'd0, 8'h33);
        check("R9 value after restart", load_val[15:0], 16'h3322);
        rd(2'd0, 8'h34, "R9 live low");
        wr(2'd3, 8'h34);
        rd(2'd0, 8'h34, "R9 read restarted");

        // R10 command-port read leaves the toggle alone
        rd(2'd3, 8'h00, "R10 zero");
        rd(2'd0, 8'h12, "R10 no side effect");

        // R2 mode remap and BCD
        wr(2'd3, 8'h1E);
        check("R2 mode 7->3", ch_mode[2:0], 3'd3);
        check("R2 access", ch_access[1:0], 2'd1);
        check("R2 bcd", ch_bcd[0], 1'b0);
        wr(2'd3, 8'h1D);
        check("R2 mode 6->2", ch_mode[2:0], 3'd2);
        check("R2 bcd set", ch_bcd[0], 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule